// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

The block collects eight interrupt request lines for one processor core. Each line has a software-programmed priority level. The block tracks which requests are pending and chooses the strongest one. If that request outranks the current mask level, the block pulls an active-low interrupt line to the core. The vector of the chosen request is held in a register, and the handler reads that register to learn which source to serve.

That read is also the acknowledge. It releases the interrupt line, saves the current mask level on a small last-in-first-out stack, and raises the mask to the level of the request being served. From then on, only a request of a strictly higher level can interrupt the handler again. When the handler clears the pending bit of the request it is serving, the saved level comes back off the stack. Handlers therefore nest to the depth of the stack.

All registers sit on a simple synchronous bus with one access per cycle. Reads return data combinationally in the cycle of the access. Writes and read side effects take effect at the clock edge that ends that cycle.

Top module: `npic_top`

## Requirements
- R1: A rising edge on `req_in[i]` sets pending bit i at the next clock edge. Writing a one to bit i of the pending register (address 0xA) clears that bit, and an input that stays high does not set it again. If a rising edge and a clear hit the same bit in the same cycle, the bit ends up set. Reading 0xA returns the pending bits, with input i at bit i.
- R2: Address i (0x0 to 0x7) holds the 3-bit level of input i in bits 2:0. A level of 0 disables the input: it is never selected and never drives the interrupt line.
- R3: Among pending, enabled inputs, the one with the numerically largest level is selected.
- R4: When several selected candidates share the largest level, the lowest input index wins.
- R5: `irq_n` is 0 exactly when a request is selected and its level is strictly greater than the mask level. A request whose level equals the mask level is held off.
- R6: In every cycle in which `irq_n` is 0, the vector register is reloaded with 0x40 plus the index of the selected input. The value appears at address 0x9 from the following cycle onwards, and the register holds its value while `irq_n` is 1.
- R7: A read of address 0x9 counts as acceptance if `irq_n` has been 0 for at least one full cycle. An acceptance pushes the mask level and sets the mask to the level of the vector that was returned, after which `irq_n` is 1 unless a stronger request is pending. A read of 0x9 at any other time has no side effect.
- R8: A write to 0xA that clears the input on top of the stack pops the stack and restores the saved mask. A clear of any other input leaves the mask level unchanged.
- R9: If a request above the raised mask becomes pending while a handler runs, `irq_n` goes to 0 again, even when that request arrives in the same cycle as an acceptance. Its acceptance pushes another level.
- R10: The stack holds four entries. An acceptance while it is full still raises the mask, drops the entry, and sets a sticky overflow flag at bit 0 of address 0xB. A clear while the stack is empty leaves the mask unchanged.
- R11: Address 0x8 reads and writes the mask level in bits 2:0.
- R12: After reset, all levels, the mask, the pending bits, the vector register and the overflow flag read 0, and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 8 | Interrupt request lines, rising edge sets pending |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read |
| irq_n | output | 1 | Interrupt to the core, active low |

## Verification
Two collisions get dedicated stimulus. In the first, a vector read that accepts one request and the rising edge of a stronger request fall on the same clock edge. The bench judges it by checking that the mask takes the accepted level and that `irq_n` falls again in the very next cycle with the new vector. In the second, a rising edge and a write-one-to-clear hit the same pending bit in one cycle. The pending register must read back set afterwards. A full nesting run to five levels covers the overflow push and the clear of an input that is not on top of the stack.

// File: rtl/npic_pkg.sv
package npic_pkg;

    localparam int N_REQ      = 8;
    localparam int LVL_W      = 3;
    localparam int IDX_W      = $clog2(N_REQ);
    localparam int STK_DEPTH  = 4;
    localparam int STK_IDX_W  = $clog2(STK_DEPTH);
    localparam int STK_PTR_W  = $clog2(STK_DEPTH + 1);
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 8;

    localparam logic [DATA_W-1:0] VEC_BASE = 8'h40;

    localparam logic [ADDR_W-1:0] A_MASK = 4'h8;
    localparam logic [ADDR_W-1:0] A_VEC  = 4'h9;
    localparam logic [ADDR_W-1:0] A_PEND = 4'hA;
    localparam logic [ADDR_W-1:0] A_STAT = 4'hB;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic valid;
        idx_t idx;
        lvl_t lvl;
    } win_t;

    typedef struct packed {
        lvl_t lvl;
        idx_t idx;
    } stk_ent_t;

    function automatic logic [DATA_W-1:0] vec_of(idx_t i);
        return VEC_BASE + DATA_W'(i);
    endfunction

endpackage

// File: rtl/npic_pend.sv
module npic_pend
    import npic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] req_in,
    input  logic [N_REQ-1:0] clr,
    output logic [N_REQ-1:0] pend
);
    logic [N_REQ-1:0] req_d;
    logic [N_REQ-1:0] rise;

    assign rise = req_in & ~req_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d <= '0;
            pend  <= '0;
        end else begin
            req_d <= req_in;
            // a fresh edge wins over a clear in the same cycle
            pend  <= (pend & ~clr) | rise;
        end
    end
endmodule

// File: rtl/npic_arb.sv
module npic_arb
    import npic_pkg::*;
(
    input  lvl_t [N_REQ-1:0] prio,
    input  logic [N_REQ-1:0] pend,
    output win_t             win
);
    always_comb begin
        win = '0;
        // ascending scan with strict compare keeps the lowest index on ties
        for (int i = 0; i < N_REQ; i++) begin
            if (pend[i] && (prio[i] != '0) && (!win.valid || prio[i] > win.lvl)) begin
                win.valid = 1'b1;
                win.idx   = IDX_W'(i);
                win.lvl   = prio[i];
            end
        end
    end
endmodule

// File: rtl/npic_mstk.sv
module npic_mstk
    import npic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ack,
    input  lvl_t                 ack_lvl,
    input  idx_t                 ack_idx,
    input  logic [N_REQ-1:0]     clr,
    input  logic                 sw_wr,
    input  lvl_t                 sw_lvl,
    output lvl_t                 mask_lvl,
    output logic                 ovf,
    output logic [STK_PTR_W-1:0] depth
);
    stk_ent_t             stk [STK_DEPTH];
    logic [STK_IDX_W-1:0] top_ptr;
    logic                 full;
    logic                 pop_hit;

    assign full    = (depth == STK_PTR_W'(STK_DEPTH));
    assign top_ptr = STK_IDX_W'(depth - 1'b1);
    assign pop_hit = (depth != '0) && clr[stk[top_ptr].idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_lvl <= '0;
            ovf      <= 1'b0;
            depth    <= '0;
            for (int k = 0; k < STK_DEPTH; k++) stk[k] <= '0;
        end else if (ack) begin
            if (full) begin
                ovf <= 1'b1;
            end else begin
                stk[depth[STK_IDX_W-1:0]] <= '{lvl: mask_lvl, idx: ack_idx};
                depth <= depth + 1'b1;
            end
            mask_lvl <= ack_lvl;
        end else if (pop_hit) begin
            mask_lvl <= stk[top_ptr].lvl;
            depth    <= depth - 1'b1;
        end else if (sw_wr) begin
            mask_lvl <= sw_lvl;
        end
    end
endmodule

// File: rtl/npic_top.sv
module npic_top
    import npic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_REQ-1:0]  req_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n
);
    lvl_t [N_REQ-1:0]     prio_q;
    logic [N_REQ-1:0]     pend;
    logic [N_REQ-1:0]     clr;
    win_t                 win;
    lvl_t                 mask_lvl;
    logic                 ovf;
    logic [STK_PTR_W-1:0] depth;
    logic [DATA_W-1:0]    vec_q;
    lvl_t                 vec_lvl;
    idx_t                 vec_idx;
    logic                 vec_vld;
    logic                 irq_on;
    logic                 ack;
    logic                 wr_en;
    logic                 rd_en;

    assign wr_en = bus_sel & bus_wr;
    assign rd_en = bus_sel & ~bus_wr;
    assign clr   = (wr_en && bus_addr == A_PEND) ? bus_wdata[N_REQ-1:0] : '0;

    npic_pend u_pend (
        .clk    (clk),
        .rst    (rst),
        .req_in (req_in),
        .clr    (clr),
        .pend   (pend)
    );

    npic_arb u_arb (
        .prio (prio_q),
        .pend (pend),
        .win  (win)
    );

    assign irq_on = win.valid && (win.lvl > mask_lvl);
    assign irq_n  = ~irq_on;
    assign ack    = rd_en && (bus_addr == A_VEC) && irq_on && vec_vld;

    npic_mstk u_mstk (
        .clk      (clk),
        .rst      (rst),
        .ack      (ack),
        .ack_lvl  (vec_lvl),
        .ack_idx  (vec_idx),
        .clr      (clr),
        .sw_wr    (wr_en && bus_addr == A_MASK),
        .sw_lvl   (bus_wdata[LVL_W-1:0]),
        .mask_lvl (mask_lvl),
        .ovf      (ovf),
        .depth    (depth)
    );

    generate
        for (genvar g = 0; g < N_REQ; g++) begin : g_prio
            always_ff @(posedge clk) begin
                if (rst)
                    prio_q[g] <= '0;
                else if (wr_en && bus_addr == ADDR_W'(g))
                    prio_q[g] <= bus_wdata[LVL_W-1:0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q   <= '0;
            vec_lvl <= '0;
            vec_idx <= '0;
            vec_vld <= 1'b0;
        end else begin
            vec_vld <= irq_on;
            if (irq_on) begin
                vec_q   <= vec_of(win.idx);
                vec_lvl <= win.lvl;
                vec_idx <= win.idx;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            if (bus_addr < ADDR_W'(N_REQ))
                bus_rdata = DATA_W'(prio_q[bus_addr[IDX_W-1:0]]);
            else if (bus_addr == A_MASK)
                bus_rdata = DATA_W'(mask_lvl);
            else if (bus_addr == A_VEC)
                bus_rdata = vec_q;
            else if (bus_addr == A_PEND)
                bus_rdata = DATA_W'(pend);
            else if (bus_addr == A_STAT)
                bus_rdata = DATA_W'(ovf);
        end
    end
endmodule

// File: rtl/npic_chk.sv
module npic_chk
    import npic_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 irq_n,
    input logic                 ack,
    input lvl_t                 vec_lvl,
    input logic                 win_valid,
    input lvl_t                 win_lvl,
    input lvl_t                 mask_lvl,
    input logic                 ovf,
    input logic [STK_PTR_W-1:0] depth,
    input logic                 bus_sel,
    input logic                 bus_wr
);
    // R2
    irq_needs_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (win_valid && win_lvl != '0));

    // R7
    ack_sets_mask_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> (mask_lvl == $past(vec_lvl)));

    // R11
    mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!(bus_sel && bus_wr) && !ack) |=> $stable(mask_lvl));

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R10
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        depth <= STK_PTR_W'(STK_DEPTH));

    // R10
    ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && depth != STK_PTR_W'(STK_DEPTH) && !ovf) |=> !ovf);
endmodule

bind npic_top npic_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_n     (irq_n),
    .ack       (ack),
    .vec_lvl   (vec_lvl),
    .win_valid (win.valid),
    .win_lvl   (win.lvl),
    .mask_lvl  (mask_lvl),
    .ovf       (ovf),
    .depth     (depth),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr)
);

// File: tb/npic_top_tb_top.sv
`timescale 1ns/1ps
module npic_top_tb_top;
    import npic_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_REQ-1:0]  req_in = '0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    npic_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_in    (req_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_n     (irq_n)
    );

    localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_REQ = 3'd2, OP_IRQ = 3'd3, OP_IDLE = 3'd4;

    typedef struct packed {
        logic [2:0] op;
        logic [3:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
        logic [3:0] rq;
    } step_t;

    localparam int N_STEPS = 34;
    localparam step_t STEPS [0:N_STEPS-1] = '{
        '{OP_WR,   4'h0, 8'h03, 8'h00, 4'd0},
        '{OP_WR,   4'h1, 8'h05, 8'h00, 4'd0},
        '{OP_WR,   4'h2, 8'h05, 8'h00, 4'd0},
        '{OP_WR,   4'h3, 8'h00, 8'h00, 4'd0},
        '{OP_REQ,  4'h0, 8'h08, 8'h00, 4'd0},
        '{OP_IRQ,  4'h0, 8'h00, 8'h01, 4'd2},   // R2 level 0 input stays silent
        '{OP_RD,   4'hA, 8'h00, 8'h08, 4'd1},   // R1 pending set by edge
        '{OP_WR,   4'hA, 8'h08, 8'h00, 4'd0},
        '{OP_RD,   4'hA, 8'h00, 8'h00, 4'd1},   // R1 held-high input not re-set
        '{OP_REQ,  4'h0, 8'h01, 8'h00, 4'd0},
        '{OP_IRQ,  4'h0, 8'h00, 8'h00, 4'd5},   // R5 level 3 above mask 0
        '{OP_IDLE, 4'h0, 8'h00, 8'h00, 4'd0},
        '{OP_RD,   4'h9, 8'h00, 8'h40, 4'd6},   // R6 vector of input 0
        '{OP_IRQ,  4'h0, 8'h00, 8'h01, 4'd7},   // R7 released by acceptance
        '{OP_RD,   4'h8, 8'h00, 8'h03, 4'd7},   // R7 mask raised
        '{OP_REQ,  4'h0, 8'h07, 8'h00, 4'd0},
        '{OP_IRQ,  4'h0, 8'h00, 8'h00, 4'd9},   // R9 preemption
        '{OP_IDLE, 4'h0, 8'h00, 8'h00, 4'd0},
        '{OP_RD,   4'h9, 8'h00, 8'h41, 4'd4},   // R3 R4 level 5 beats 3, input 1 beats 2
        '{OP_RD,   4'h8, 8'h00, 8'h05, 4'd9},   // R9 nested mask
        '{OP_IRQ,  4'h0, 8'h00, 8'h01, 4'd5},   // R5 equal level held off
        '{OP_WR,   4'hA, 8'h04, 8'h00, 4'd0},
        '{OP_RD,   4'h8, 8'h00, 8'h05, 4'd8},   // R8 non-top clear
        '{OP_WR,   4'hA, 8'h02, 8'h00, 4'd0},
        '{OP_RD,   4'h8, 8'h00, 8'h03, 4'd8},   // R8 top clear restores
        '{OP_WR,   4'hA, 8'h01, 8'h00, 4'd0},
        '{OP_RD,   4'h8, 8'h00, 8'h00, 4'd8},
        '{OP_RD,   4'h9, 8'h00, 8'h41, 4'd7},   // R7 read with irq_n high
        '{OP_RD,   4'h8, 8'h00, 8'h00, 4'd7},   // R7 no side effect
        '{OP_WR,   4'hA, 8'h01, 8'h00, 4'd0},
        '{OP_RD,   4'h8, 8'h00, 8'h00, 4'd10},  // R10 empty-stack clear
        '{OP_WR,   4'h8, 8'h02, 8'h00, 4'd0},
        '{OP_RD,   4'h8, 8'h00, 8'h02, 4'd11},  // R11 mask write
        '{OP_REQ,  4'h0, 8'h00, 8'h00, 4'd0}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input int rq, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %02h expected %02h", rq, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input int rq);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5;
        check(rq, $sformatf("read %h", a), bus_rdata, exp);
        tick();
        bus_sel = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input int rq);
        check(rq, "irq_n", {7'd0, irq_n}, {7'd0, e});
    endtask

    task automatic do_reset();
        rst = 1'b1; req_in = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R12 reset state
        chk_irq(1'b1, 12);
        rd(4'h8, 8'h00, 12);
        rd(4'hA, 8'h00, 12);
        rd(4'h9, 8'h00, 12);
        rd(4'hB, 8'h00, 12);
        rd(4'h5, 8'h00, 12);

        for (int s = 0; s < N_STEPS; s++) begin
            case (STEPS[s].op)
                OP_WR:   wr(STEPS[s].addr, STEPS[s].data);
                OP_RD:   rd(STEPS[s].addr, STEPS[s].exp, int'(STEPS[s].rq));
                OP_REQ:  begin req_in = STEPS[s].data; tick(); end
                OP_IRQ:  chk_irq(STEPS[s].exp[0], int'(STEPS[s].rq));
                default: tick();
            endcase
        end

        // R1 edge and clear on the same bit in one cycle: set wins
        wr(4'h4, 8'h01);
        req_in = 8'h10;
        wr(4'hA, 8'h10);
        rd(4'hA, 8'h10, 1);
        chk_irq(1'b1, 5);              // R5 level 1 under mask 2
        wr(4'hA, 8'h10);
        rd(4'hA, 8'h00, 1);
        req_in = 8'h00; tick();

        // R9 acceptance and a stronger edge on the same clock edge
        wr(4'h4, 8'h04);
        wr(4'h5, 8'h06);
        req_in = 8'h10; tick();
        chk_irq(1'b0, 5);
        tick();
        req_in = 8'h30;
        rd(4'h9, 8'h44, 6);
        chk_irq(1'b0, 9);
        tick();
        rd(4'h9, 8'h45, 9);
        rd(4'h8, 8'h06, 9);
        wr(4'hA, 8'h20);
        rd(4'h8, 8'h04, 8);
        wr(4'hA, 8'h10);
        rd(4'h8, 8'h02, 8);
        req_in = 8'h00; tick();

        // R10 five nested acceptances overflow the four-entry stack
        do_reset();
        rd(4'hB, 8'h00, 12);
        for (int i = 0; i < 5; i++) wr(4'(i), 8'(i + 1));
        for (int i = 0; i < 5; i++) begin
            req_in[i] = 1'b1;
            tick();
            chk_irq(1'b0, 5);
            tick();
            rd(4'h9, 8'h40 + 8'(i), 6);
            chk_irq(1'b1, 7);
        end
        rd(4'hB, 8'h01, 10);
        rd(4'h8, 8'h05, 10);
        wr(4'hA, 8'h10);
        rd(4'h8, 8'h05, 8);            // R8 overflowed entry not on top
        wr(4'hA, 8'h08);
        rd(4'h8, 8'h03, 8);
        rd(4'hB, 8'h01, 10);

        finish_run();
    end
endmodule